// File: doc/BRIEF.md
# Read Strobe Tracker

This block keeps count of DRAM reads that have been issued but not yet answered. Each read command enters a small in-order queue together with a tag and a burst-length flag. The memory answers with read strobe edges. These edges arrive here already synchronized, one clock-wide pulse per edge. The block counts them against the oldest queued command. When that command has received all of its strobes, the command leaves the queue and its tag is reported on a one-cycle completion output.

The strobe count and the command stream can disagree, for example because of a bad interface or wrong latency settings. Two cases are handled:

- A strobe that arrives while nothing is outstanding is an underflow.
- A command that arrives while the queue is full is an overflow.

Both cases are recorded in sticky pending flags. A small CPU register window lets software read the flags, clear them by writing 1, and enable each one onto a shared interrupt line. Neither case ever stops the queue or the strobe counter.

Top module: `read_strobe_tracker`

## Requirements
- R1: Right after a synchronous reset, `done_valid` and `irq_out` are 0, both status flags are 0, both enables are 0, and `reg_rdata` reads 0.
- R2: A command with `cmd_long`=1 needs 4 strobes. After its 4th strobe, `done_valid` is 1 for exactly one cycle, on the clock edge that samples that strobe, and `done_tag` equals its tag. After 3 strobes nothing completes.
- R3: A command with `cmd_long`=0 needs 2 strobes and completes after the 2nd strobe in the same way.
- R4: Commands complete strictly in the order they were accepted, and mixed burst lengths are allowed.
- R5: A strobe that arrives while no command is queued sets the underflow flag (status bit 1). The strobe is otherwise ignored and the beat counter stays at zero, so the next command still needs its full strobe count.
- R6: A command that arrives while 8 commands are queued, and no completion happens in that cycle, sets the overflow flag (status bit 0). That command is dropped and never completes.
- R7: Writing to address 0 clears each status flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R8: If a clearing write and a new event hit the same flag in the same cycle, the flag stays set.
- R9: Address 1 holds the enables (bit 0 for overflow, bit 1 for underflow). `irq_out` is 1 exactly when some flag and its enable are both set, and it follows flag or enable changes on the same clock edge.
- R10: After an overflow or an underflow, commands and strobes keep working normally. The queue occupancy never exceeds 8.
- R11: A command that arrives while the queue is full is accepted without an overflow when the head completes in that same cycle.
- R12: `reg_rdata` shows the register chosen by `reg_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A read command is issued this cycle |
| cmd_tag | input | 4 | Tag of the issued command |
| cmd_long | input | 1 | 1: burst of 4 strobes, 0: burst of 2 strobes |
| strobe_pulse | input | 1 | One synchronized read strobe edge |
| done_valid | output | 1 | The head command has completed (one-cycle pulse) |
| done_tag | output | 4 | Tag of the completed command |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: status flags, 1: enables |
| reg_wdata | input | 2 | Write data (bit 0 overflow, bit 1 underflow) |
| reg_rdata | output | 2 | Registered read data of the selected register |
| irq_out | output | 1 | Interrupt request |

## Verification
Several command and strobe patterns are applied:

- A lone long burst and a lone short burst are driven with one strobe fewer than needed and then with the last strobe. This separates a counter that retires early from one that retires late.
- A mix of long and short bursts shows whether the per-entry burst flag travels with its tag and whether ordering holds.
- The queue is filled to capacity with one extra command. This is repeated with the extra command landing in a retiring cycle, which separates a plain full check from one that accounts for the simultaneous completion.
- Stray strobes are sent on an empty queue, once alone and once together with a clearing write. These show whether the stray edge leaks into the beat count and whether the event beats the clear.

// File: rtl/strb_trk_pkg.sv
package strb_trk_pkg;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  localparam int BIT_OV = 0;
  localparam int BIT_UV = 1;

  // Packed so that bit 1 = underflow, bit 0 = overflow
  typedef struct packed {
    logic uv;
    logic ov;
  } err_bits_t;

endpackage

// File: rtl/strb_trk_fifo.sv
module strb_trk_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));

endmodule

// File: rtl/strb_trk_beats.sv
module strb_trk_beats #(
  parameter int LONG_BEATS  = 4,
  parameter int SHORT_BEATS = 2,
  localparam int CNT_W = $clog2(LONG_BEATS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic empty,
  input  logic head_long,
  output logic retire,
  output logic uv_event
);

  logic [CNT_W-1:0] beat_cnt, beat_nxt, need;

  assign need     = head_long ? CNT_W'(LONG_BEATS) : CNT_W'(SHORT_BEATS);
  assign beat_nxt = beat_cnt + 1'b1;
  assign uv_event = strobe & empty;
  assign retire   = strobe & ~empty & (beat_nxt == need);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt <= '0;
    end else if (strobe) begin
      if (empty || retire) beat_cnt <= '0;
      else                 beat_cnt <= beat_nxt;
    end
  end

endmodule

// File: rtl/strb_trk_regs.sv
module strb_trk_regs
  import strb_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ov_event,
  input  logic       uv_event,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [1:0] reg_wdata,
  output logic [1:0] reg_rdata,
  output logic       ov_pend,
  output logic       uv_pend,
  output logic       ov_en,
  output logic       uv_en,
  output logic       irq_out
);

  err_bits_t pend_q, pend_d, en_q, en_d;

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    if (reg_wr && reg_addr == ADDR_STATUS) begin
      if (reg_wdata[BIT_OV]) pend_d.ov = 1'b0;
      if (reg_wdata[BIT_UV]) pend_d.uv = 1'b0;
    end
    if (reg_wr && reg_addr == ADDR_ENABLE) begin
      en_d.ov = reg_wdata[BIT_OV];
      en_d.uv = reg_wdata[BIT_UV];
    end
    // A fresh event takes priority over a clear in the same cycle
    if (ov_event) pend_d.ov = 1'b1;
    if (uv_event) pend_d.uv = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      en_q      <= '0;
      irq_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      pend_q    <= pend_d;
      en_q      <= en_d;
      irq_out   <= (pend_d.ov & en_d.ov) | (pend_d.uv & en_d.uv);
      reg_rdata <= (reg_addr == ADDR_STATUS) ? pend_q : en_q;
    end
  end

  assign ov_pend = pend_q.ov;
  assign uv_pend = pend_q.uv;
  assign ov_en   = en_q.ov;
  assign uv_en   = en_q.uv;

endmodule

// File: rtl/read_strobe_tracker.sv
module read_strobe_tracker #(
  parameter int DEPTH       = 8,
  parameter int TAG_W       = 4,
  parameter int LONG_BEATS  = 4,
  parameter int SHORT_BEATS = 2,
  localparam int ENT_W = TAG_W + 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             cmd_long,
  input  logic             strobe_pulse,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [1:0]       reg_wdata,
  output logic [1:0]       reg_rdata,
  output logic             irq_out
);

  logic             fifo_empty, fifo_full;
  logic [LVL_W-1:0] fifo_level;
  logic [ENT_W-1:0] head;
  logic             retire, uv_event, ov_event, accept;
  logic             ov_pend, uv_pend, ov_en, uv_en;

  assign accept   = cmd_valid & (~fifo_full | retire);
  assign ov_event = cmd_valid & fifo_full & ~retire;

  strb_trk_fifo #(
    .DEPTH (DEPTH),
    .W     (ENT_W)
  ) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   ({cmd_tag, cmd_long}),
    .pop   (retire),
    .dout  (head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  strb_trk_beats #(
    .LONG_BEATS  (LONG_BEATS),
    .SHORT_BEATS (SHORT_BEATS)
  ) u_beats (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe_pulse),
    .empty     (fifo_empty),
    .head_long (head[0]),
    .retire    (retire),
    .uv_event  (uv_event)
  );

  strb_trk_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .ov_event  (ov_event),
    .uv_event  (uv_event),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ov_pend   (ov_pend),
    .uv_pend   (uv_pend),
    .ov_en     (ov_en),
    .uv_en     (uv_en),
    .irq_out   (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
    end else begin
      done_valid <= retire;
      if (retire) done_tag <= head[ENT_W-1:1];
    end
  end

endmodule

// File: rtl/read_strobe_tracker_chk.sv
module read_strobe_tracker_chk
  import strb_trk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             strobe_pulse,
  input logic             done_valid,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic [LVL_W-1:0] fifo_level,
  input logic             retire,
  input logic             uv_event,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [1:0]       reg_wdata,
  input logic             ov_pend,
  input logic             uv_pend,
  input logic             ov_en,
  input logic             uv_en,
  input logic             irq_out
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done_valid |=> !done_valid); // R2
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst) done_valid |-> $past(strobe_pulse)); // R3
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst) (strobe_pulse && fifo_empty) |=> uv_pend); // R5
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst) (cmd_valid && fifo_full && !retire) |=> ov_pend); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[BIT_UV] && !uv_event) |=> !uv_pend); // R7
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst) (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[BIT_UV] && uv_event) |=> uv_pend); // R8
  AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (rst) irq_out == ((ov_pend && ov_en) || (uv_pend && uv_en))); // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst) fifo_level <= LVL_W'(DEPTH)); // R10

endmodule

bind read_strobe_tracker read_strobe_tracker_chk #(
  .DEPTH (DEPTH),
  .LVL_W (LVL_W)
) u_chk (.*);

// File: tb/test_read_strobe_tracker.sv
`timescale 1ns/1ps
module test_read_strobe_tracker;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid, cmd_long, strobe_pulse;
  logic [3:0] cmd_tag;
  logic       done_valid;
  logic [3:0] done_tag;
  logic       reg_wr, reg_addr;
  logic [1:0] reg_wdata, reg_rdata;
  logic       irq_out;

  int vectors = 0;
  int miscompares = 0;
  int log_tag[64];
  int log_n = 0;

  always #4 clk = ~clk;

  read_strobe_tracker i_read_strobe_tracker (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_tag      (cmd_tag),
    .cmd_long     (cmd_long),
    .strobe_pulse (strobe_pulse),
    .done_valid   (done_valid),
    .done_tag     (done_tag),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_out      (irq_out)
  );

  always @(negedge clk) begin
    if (done_valid === 1'b1) begin
      if (log_n < 64) log_tag[log_n] = int'(done_tag);
      log_n++;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input int tag, input bit long_b);
    cmd_valid = 1'b1;
    cmd_tag   = 4'(tag);
    cmd_long  = long_b;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      strobe_pulse = 1'b1;
      step();
    end
    strobe_pulse = 1'b0;
  endtask

  task automatic wr_reg(input bit a, input logic [1:0] d);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    step();
    reg_wr    = 1'b0;
  endtask

  // R12: data for the address shows up one clock later
  task automatic rd_reg(input bit a, output int v);
    reg_addr = a;
    step();
    v = int'(reg_rdata);
  endtask

  task automatic t_reset();
    int v;
    rst = 1'b1;
    step(); step(); step();
    rst = 1'b0;
    check("R1 done_valid after reset", int'(done_valid), 0);
    check("R1 irq after reset", int'(irq_out), 0);
    check("R1 rdata after reset", int'(reg_rdata), 0);
    rd_reg(1'b0, v); check("R1 R12 status after reset", v, 0);
    rd_reg(1'b1, v); check("R1 R12 enable after reset", v, 0);
  endtask

  task automatic t_long();
    int base = log_n;
    cmd(5, 1'b1);
    strobes(3);
    check("R2 no completion after 3 strobes", int'(done_valid), 0);
    strobes(1);
    check("R2 completion after 4th strobe", int'(done_valid), 1);
    check("R2 tag", int'(done_tag), 5);
    step();
    check("R2 single pulse", int'(done_valid), 0);
    check("R2 one completion", log_n - base, 1);
  endtask

  task automatic t_short();
    cmd(10, 1'b0);
    strobes(1);
    check("R3 no completion after 1 strobe", int'(done_valid), 0);
    strobes(1);
    check("R3 completion after 2nd strobe", int'(done_valid), 1);
    check("R3 tag", int'(done_tag), 10);
  endtask

  task automatic t_order();
    int base = log_n;
    cmd(1, 1'b1);
    cmd(2, 1'b0);
    cmd(3, 1'b1);
    strobes(10);
    check("R4 three completions", log_n - base, 3);
    check("R4 first tag", log_tag[base], 1);
    check("R4 second tag", log_tag[base + 1], 2);
    check("R4 third tag", log_tag[base + 2], 3);
  endtask

  task automatic t_underflow();
    int v;
    wr_reg(1'b1, 2'b10);
    strobes(1);
    check("R9 irq on enabled underflow", int'(irq_out), 1);
    rd_reg(1'b0, v); check("R5 underflow flag", v, 2);
    cmd(7, 1'b0);
    strobes(1);
    check("R5 stray strobe not counted", int'(done_valid), 0);
    strobes(1);
    check("R10 completion after underflow", int'(done_valid), 1);
    check("R10 tag after underflow", int'(done_tag), 7);
    wr_reg(1'b0, 2'b01);
    rd_reg(1'b0, v); check("R7 zero bit leaves flag", v, 2);
    wr_reg(1'b0, 2'b10);
    rd_reg(1'b0, v); check("R7 one bit clears flag", v, 0);
    check("R9 irq drops after clear", int'(irq_out), 0);
    wr_reg(1'b1, 2'b00);
  endtask

  task automatic t_overflow();
    int v;
    int base;
    for (int t = 0; t < 8; t++) cmd(t, 1'b0);
    cmd(9, 1'b0);
    rd_reg(1'b0, v); check("R6 overflow flag", v, 1);
    check("R9 irq gated by enable", int'(irq_out), 0);
    wr_reg(1'b1, 2'b01);
    check("R9 irq on enable write", int'(irq_out), 1);
    wr_reg(1'b1, 2'b00);
    check("R9 irq off on disable", int'(irq_out), 0);
    base = log_n;
    strobes(16);
    check("R6 dropped command absent", log_n - base, 8);
    for (int t = 0; t < 8; t++) check("R6 R10 tag order after overflow", log_tag[base + t], t);
    strobes(1);
    rd_reg(1'b0, v); check("R5 R10 both flags", v, 3);
    wr_reg(1'b0, 2'b11);
    rd_reg(1'b0, v); check("R7 both cleared", v, 0);
  endtask

  task automatic t_full_retire();
    int v;
    int base = log_n;
    for (int t = 8; t < 16; t++) cmd(t, 1'b0);
    strobes(1);
    strobe_pulse = 1'b1;
    cmd_valid    = 1'b1;
    cmd_tag      = 4'd3;
    cmd_long     = 1'b0;
    step();
    strobe_pulse = 1'b0;
    cmd_valid    = 1'b0;
    check("R11 head retires", int'(done_tag), 8);
    strobes(16);
    check("R11 all completions", log_n - base, 9);
    check("R11 accepted tag last", log_tag[base + 8], 3);
    rd_reg(1'b0, v); check("R11 no overflow", v, 0);
  endtask

  task automatic t_clear_race();
    int v;
    strobe_pulse = 1'b1;
    reg_wr       = 1'b1;
    reg_addr     = 1'b0;
    reg_wdata    = 2'b10;
    step();
    strobe_pulse = 1'b0;
    reg_wr       = 1'b0;
    rd_reg(1'b0, v); check("R8 event wins over clear", v, 2);
    wr_reg(1'b0, 2'b10);
    rd_reg(1'b0, v); check("R8 later clear works", v, 0);
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cmd_valid = 1'b0; cmd_tag = '0; cmd_long = 1'b0; strobe_pulse = 1'b0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    @(negedge clk); #1;
    t_reset();
    t_long();
    t_short();
    t_order();
    t_underflow();
    t_overflow();
    t_full_retire();
    t_clear_race();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule